// File: doc/BRIEF.md
# Memory Access Response Watchdog

This block guards the handshake between a memory controller and the message memory attached to it. When the controller starts an access, an 8-bit down-counter is loaded from a configured start value. The counter then counts down by one on every clock of the peripheral bus clock until the memory answers with its ready output. Ready reloads the counter and closes the access. If the counter reaches zero first, it stops there and raises a sticky watchdog flag. Software reads the flag and clears it with a write-one-to-clear strobe.

A configured start value of zero turns the watchdog off. The live counter value can be read back together with the configuration. In the readback word the configured value sits in bits 7:0 and the live count sits in bits 15:8. The memory itself and the register bus decode lie outside this block.

Top module: `mem_resp_watchdog`

## Requirements
- R1: After reset the counter reads 0, the flag reads 0 and no access is outstanding.
- R2: An access start while the configured value is nonzero loads the counter with that value at the next clock edge, and the access becomes outstanding.
- R3: While an access is outstanding and neither ready nor a start is present, the counter drops by exactly one per clock. With no access outstanding the counter holds its value.
- R4: Ready during an outstanding access reloads the counter with the configured value at the next edge and ends the access, so the counter then holds.
- R5: When the counter steps from 1 to 0 with no ready present, the flag sets at that same edge. The counter then stays at 0 and never wraps, until the next access start.
- R6: The flag stays set until a clear strobe is seen at a clock edge. If a clear and an expiry fall in the same cycle, the flag ends up set.
- R7: A configured value of zero disables the watchdog. An access start is then ignored: the counter keeps its value, the access is not armed, and the flag cannot set.
- R8: Ready while no access is outstanding has no effect on the counter or the flag.
- R9: The readback word carries the configured value in bits 7:0 and the live counter value in bits 15:8.
- R10: An access start during an outstanding access restarts the count from the configured value. A start outranks a ready arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| accessStart | input | 1 | One-cycle pulse when a memory access begins |
| memReady | input | 1 | Memory completion handshake |
| startVal | input | 8 | Configured watchdog start value; 0 disables the watchdog |
| flagClear | input | 1 | Write-one-to-clear strobe for the flag |
| countVal | output | 8 | Live counter value |
| wdFlag | output | 1 | Sticky watchdog timeout flag |
| regWord | output | 16 | Readback word: {countVal, startVal} |

## Verification
The assertions assume that every input is synchronous to the clock and known after reset. They also assume that the counter is only ever armed with a nonzero value, so an outstanding access never holds a count of zero. The stimulus drives all inputs on the falling edge. It changes the configured value freely, zero included, and pulses starts, ready and clears at random with a fixed seed. Directed sequences then force the corner cases: same-cycle start and ready, same-cycle clear and expiry, and idle ready. Each step is compared with a cycle-level model in the bench.

// File: rtl/mem_resp_watchdog_pkg.sv
package mem_resp_watchdog_pkg;

  // strobes from the control path to the datapath
  typedef struct packed {
    logic load;    // load counter from configured value
    logic dec;     // count down by one
    logic expire;  // force zero and raise flag
    logic clr;     // clear flag request
  } wdStrobes_t;

  typedef enum logic {
    WD_IDLE = 1'b0,
    WD_WAIT = 1'b1
  } wdState_t;

endpackage

// File: rtl/mem_resp_watchdog_ctrl.sv
module mem_resp_watchdog_ctrl
  import mem_resp_watchdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accessStart,
  input  logic       memReady,
  input  logic       flagClear,
  input  logic       cfgNonZero,
  input  logic       cntIsOne,
  output wdStrobes_t strobes
);

  wdState_t state, stateNext;
  logic     startOk;
  logic     busy;

  assign busy    = (state == WD_WAIT);
  assign startOk = accessStart && cfgNonZero;

  always_comb begin
    strobes.load   = startOk || (busy && memReady);
    strobes.expire = busy && !startOk && !memReady && cntIsOne;
    strobes.dec    = busy && !startOk && !memReady && !cntIsOne;
    strobes.clr    = flagClear;
  end

  always_comb begin
    stateNext = state;
    if (startOk) begin
      stateNext = WD_WAIT;
    end else if (busy && (memReady || cntIsOne)) begin
      stateNext = WD_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= WD_IDLE;
    end else begin
      state <= stateNext;
    end
  end

endmodule

// File: rtl/mem_resp_watchdog_dp.sv
module mem_resp_watchdog_dp
  import mem_resp_watchdog_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobes_t       strobes,
  input  logic [CNT_W-1:0] startVal,
  output logic [CNT_W-1:0] countVal,
  output logic             cntIsOne,
  output logic             wdFlag
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt;
  logic             flag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= CNT_ZERO;
    end else if (strobes.load) begin
      cnt <= startVal;
    end else if (strobes.expire) begin
      cnt <= CNT_ZERO;
    end else if (strobes.dec) begin
      cnt <= cnt - CNT_ONE;
    end
  end

  // expiry outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (strobes.expire) begin
      flag <= 1'b1;
    end else if (strobes.clr) begin
      flag <= 1'b0;
    end
  end

  assign cntIsOne = (cnt == CNT_ONE);
  assign countVal = cnt;
  assign wdFlag   = flag;

endmodule

// File: rtl/mem_resp_watchdog.sv
module mem_resp_watchdog
  import mem_resp_watchdog_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int WORD_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessStart,
  input  logic              memReady,
  input  logic [CNT_W-1:0]  startVal,
  input  logic              flagClear,
  output logic [CNT_W-1:0]  countVal,
  output logic              wdFlag,
  output logic [WORD_W-1:0] regWord
);

  wdStrobes_t strobes;
  logic       cntIsOne;
  logic       cfgNonZero;

  assign cfgNonZero = |startVal;

  mem_resp_watchdog_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .accessStart(accessStart),
    .memReady   (memReady),
    .flagClear  (flagClear),
    .cfgNonZero (cfgNonZero),
    .cntIsOne   (cntIsOne),
    .strobes    (strobes)
  );

  mem_resp_watchdog_dp #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .startVal(startVal),
    .countVal(countVal),
    .cntIsOne(cntIsOne),
    .wdFlag  (wdFlag)
  );

  // configured value low, live count high
  assign regWord = {countVal, startVal};

endmodule

// File: rtl/mem_resp_watchdog_checker.sv
module mem_resp_watchdog_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             accessStart,
  input logic             memReady,
  input logic [CNT_W-1:0] startVal,
  input logic             flagClear,
  input logic [CNT_W-1:0] countVal,
  input logic             wdFlag
);

  // R2: nonzero start loads the configured value
  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    (accessStart && startVal != '0) |=> countVal == $past(startVal));

  // R3: without start or ready the count either holds or drops by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (!accessStart && !memReady && countVal != '0) |=>
      (countVal == $past(countVal) || countVal == $past(countVal) - 1'b1));

  // R5: flag rises only with the counter at zero
  a_r5_expire_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdFlag) |-> countVal == '0);

  // R5: zero is held until a start
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (countVal == '0 && !accessStart) |=> countVal == '0);

  // R6: flag is sticky without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (wdFlag && !flagClear) |=> wdFlag);

endmodule

bind mem_resp_watchdog mem_resp_watchdog_checker #(.CNT_W(CNT_W)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .accessStart(accessStart),
  .memReady   (memReady),
  .startVal   (startVal),
  .flagClear  (flagClear),
  .countVal   (countVal),
  .wdFlag     (wdFlag)
);

// File: tb/mem_resp_watchdog_test.sv
`timescale 1ns/1ps
module mem_resp_watchdog_test;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             accessStart = 1'b0;
  logic             memReady = 1'b0;
  logic [CNT_W-1:0] startVal = '0;
  logic             flagClear = 1'b0;
  logic [CNT_W-1:0] countVal;
  logic             wdFlag;
  logic [2*CNT_W-1:0] regWord;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  bit             mBusy = 1'b0;
  logic [CNT_W-1:0] mCnt = '0;
  bit             mFlag = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mem_resp_watchdog #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .accessStart(accessStart), .memReady(memReady),
    .startVal(startVal), .flagClear(flagClear), .countVal(countVal),
    .wdFlag(wdFlag), .regWord(regWord)
  );

  function automatic logic [CNT_W-1:0] nextCnt(bit busy, logic [CNT_W-1:0] c,
      bit st, bit rdy, logic [CNT_W-1:0] sv);
    if (st && sv != 0) return sv;
    if (busy && rdy) return sv;
    if (busy) return c - 1'b1;
    return c;
  endfunction

  function automatic bit nextBusy(bit busy, logic [CNT_W-1:0] c,
      bit st, bit rdy, logic [CNT_W-1:0] sv);
    if (st && sv != 0) return 1'b1;
    if (busy && (rdy || c == 1)) return 1'b0;
    return busy;
  endfunction

  function automatic bit nextFlag(bit f, bit busy, logic [CNT_W-1:0] c,
      bit st, bit rdy, logic [CNT_W-1:0] sv, bit clr);
    if (busy && !(st && sv != 0) && !rdy && c == 1) return 1'b1;
    if (clr) return 1'b0;
    return f;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, update model at the rising edge,
  // compare shortly after
  task automatic step(bit st, bit rdy, logic [CNT_W-1:0] sv, bit clr, string req);
    logic [CNT_W-1:0] c;
    bit b;
    bit f;
    @(negedge clk);
    accessStart = st; memReady = rdy; startVal = sv; flagClear = clr;
    @(posedge clk);
    c = nextCnt(mBusy, mCnt, st, rdy, sv);
    b = nextBusy(mBusy, mCnt, st, rdy, sv);
    f = nextFlag(mFlag, mBusy, mCnt, st, rdy, sv, clr);
    mCnt = c; mBusy = b; mFlag = f;
    #1;
    check(countVal == mCnt, req, "count", countVal, mCnt);
    check(wdFlag == mFlag, req, "flag", wdFlag, mFlag);
    check(regWord == {mCnt, sv}, "R9", "word", regWord, {mCnt, sv});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    seed = 11;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(countVal == 0, "R1", "reset count", countVal, 0);
    check(wdFlag == 0, "R1", "reset flag", wdFlag, 0);
    @(negedge clk); rstN = 1'b1;

    // R7: zero configuration ignores a start
    step(1, 0, 8'd0, 0, "R7");
    repeat (4) step(0, 0, 8'd0, 0, "R7");
    check(countVal == 0 && !wdFlag, "R7", "disabled idle", countVal, 0);

    // R2 load, R3 countdown
    step(1, 0, 8'd5, 0, "R2");
    check(countVal == 5, "R2", "load value", countVal, 5);
    step(0, 0, 8'd5, 0, "R3");
    check(countVal == 4, "R3", "one decrement", countVal, 4);
    // R4 ready reloads and ends access
    step(0, 1, 8'd5, 0, "R4");
    check(countVal == 5, "R4", "reload", countVal, 5);
    repeat (3) step(0, 0, 8'd5, 0, "R3");
    check(countVal == 5, "R3", "idle hold", countVal, 5);
    // R8 idle ready ignored
    step(0, 1, 8'd9, 0, "R8");
    check(countVal == 5 && !wdFlag, "R8", "idle ready", countVal, 5);

    // R5 expiry with value 3
    step(1, 0, 8'd3, 0, "R2");
    step(0, 0, 8'd3, 0, "R3");
    step(0, 0, 8'd3, 0, "R3");
    step(0, 0, 8'd3, 0, "R5");
    check(countVal == 0 && wdFlag, "R5", "expiry", countVal, 0);
    repeat (3) step(0, 1, 8'd3, 0, "R5");
    check(countVal == 0, "R5", "frozen at zero", countVal, 0);
    // R6 sticky then clear
    check(wdFlag == 1, "R6", "sticky", wdFlag, 1);
    step(0, 0, 8'd3, 1, "R6");
    check(wdFlag == 0, "R6", "clear", wdFlag, 0);
    // R6 clear and expiry in the same cycle
    step(1, 0, 8'd1, 0, "R2");
    step(0, 0, 8'd1, 1, "R6");
    check(wdFlag == 1, "R6", "expiry beats clear", wdFlag, 1);
    step(0, 0, 8'd1, 1, "R6");

    // R10 restart and start beats ready
    step(1, 0, 8'd6, 0, "R10");
    step(0, 0, 8'd6, 0, "R10");
    step(0, 0, 8'd6, 0, "R10");
    step(1, 1, 8'd7, 0, "R10");
    check(countVal == 7, "R10", "restart", countVal, 7);
    step(0, 0, 8'd7, 0, "R10");
    check(countVal == 6, "R10", "still armed", countVal, 6);
    step(0, 1, 8'd7, 0, "R4");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit st;
      bit rdy;
      bit clr;
      logic [CNT_W-1:0] sv;
      st  = ($urandom % 100) < 6;
      rdy = ($urandom % 100) < 4;
      clr = ($urandom % 100) < 5;
      sv  = (($urandom % 8) == 0) ? 8'd0 : CNT_W'(1 + ($urandom % 12));
      step(st, rdy, sv, clr, "R3");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule